// File: doc/BRIEF.md
# Thermal Policy Controller for a Redundant Thread Pair

This block decides, once per temperature sampling epoch, how a core that runs one program as a leading and a trailing thread should respond to heat. When the hottest on-chip structure reaches the limit, the controller first drops the trailing thread. Only if the heat stays at or above the limit over three samples in a row does it also ask for voltage and frequency scaling. Once a sample comes back cool, it returns to full redundancy. A mode input can forbid scaling entirely. In that mode the controller only switches the trailing thread off and on as the temperature crosses the limit.

The controller is driven by an epoch pulse from a sampling timer, the current hottest temperature, a limit value and a flag that marks the end of warm-up. It drives a redundancy enable, a scaling request with a latched temperature for the regulator's level choice, and a saturating count of epochs run without redundancy. A deadband parameter filters the mode decision: a sample just below the limit neither re-enables redundancy nor counts as a violation. This keeps the mode from chattering.

Top module: `thermal_redundancy_mgr`

## Requirements
- R1: After reset, `redun_en` is 1, `dvs_req` is 0, `dvs_temp` is 0 and `off_epochs` is 0.
- R2: Temperature is ignored on every epoch pulse before `warmup_done` is high and on the first epoch pulse with `warmup_done` high. Redundancy stays on through these pulses.
- R3: From full redundancy, a sample with `temp_max >= temp_thresh` (equality counts) clears `redun_en` in the cycle after the pulse, with `dvs_req` staying 0.
- R4: While redundancy is off and scaling is not engaged, a cool sample (`temp_max + HYST < temp_thresh`) sets `redun_en` again without ever raising `dvs_req`.
- R5: The third consecutive violating sample, counted from the one that dropped redundancy, raises `dvs_req`. `dvs_temp` then equals that sample and `redun_en` stays 0.
- R6: While scaling is engaged, each further violating sample reloads `dvs_temp` with the new value, and `redun_en` stays 0.
- R7: A cool sample while scaled clears `dvs_req` and sets `redun_en` in the same cycle, one cycle after the pulse.
- R8: A sample in the deadband (below the limit but not by more than `HYST`) leaves the mode unchanged. It neither advances nor resets the run of consecutive violations.
- R9: With `partial_only` high, `dvs_req` never rises and redundancy follows threshold crossings alone.
- R10: `off_epochs` increments on each epoch pulse that arrives while `redun_en` is 0, and holds at all ones.
- R11: Outputs change only in the cycle after an epoch pulse. Temperature changes between pulses have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| epoch_tick | input | 1 | One-cycle pulse at each sampling epoch |
| warmup_done | input | 1 | High once warm-up phases have finished |
| partial_only | input | 1 | 1 forbids scaling; redundancy toggling only |
| temp_max | input | TW | Hottest structure temperature for this epoch |
| temp_thresh | input | TW | Thermal limit |
| redun_en | output | 1 | Trailing thread enabled |
| dvs_req | output | 1 | Request voltage/frequency scaling |
| dvs_temp | output | TW | Latched sample used to pick the scaling level |
| off_epochs | output | CW | Saturating count of epochs without redundancy |

## Verification
The bench builds the controller with `TW=8`, `HYST=2` and `CW=3`. The three-bit counter reaches saturation within a short run, so the hold at all ones is exercised. The two-unit deadband makes a band sample (79 against a limit of 80) distinct from a cool one (77). With these values, a band sample placed inside a violation run shows the run neither advancing nor restarting. A limit-equal sample exercises the inclusive comparison.

// File: rtl/tmgr_pkg.sv
package tmgr_pkg;
  typedef enum logic [2:0] {
    ST_WARMUP  = 3'd0,
    ST_REDUN   = 3'd1,
    ST_SINGLE  = 3'd2,
    ST_SCALED  = 3'd3,
    ST_RESTORE = 3'd4
  } tmgr_state_e;
endpackage

// File: rtl/tmgr_compare.sv
module tmgr_compare #(
  parameter int TW   = 8,
  parameter int HYST = 0
) (
  input  logic [TW-1:0] temp_max,
  input  logic [TW-1:0] temp_thresh,
  output logic          hot,
  output logic          cool
);
  localparam logic [TW:0] BAND = (TW+1)'(HYST);

  assign hot = (temp_max >= temp_thresh);

  generate
    if (HYST == 0) begin : g_plain
      assign cool = ~hot;
    end else begin : g_band
      logic [TW:0] lifted;
      assign lifted = {1'b0, temp_max} + BAND;
      assign cool   = (lifted < {1'b0, temp_thresh});
    end
  endgenerate
endmodule

// File: rtl/tmgr_fsm.sv
module tmgr_fsm
  import tmgr_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick,
  input  logic        warm_done,
  input  logic        partial_only,
  input  logic        hot,
  input  logic        cool,
  output tmgr_state_e state,
  output logic        load_lvl,
  output logic        off_inc
);
  tmgr_state_e state_q, state_d;
  logic [1:0]  run_q, run_d;

  always_comb begin
    state_d  = state_q;
    run_d    = run_q;
    load_lvl = 1'b0;
    unique case (state_q)
      ST_WARMUP: begin
        if (tick && warm_done) state_d = ST_REDUN;
      end
      ST_REDUN: begin
        if (tick && hot) begin
          state_d = ST_SINGLE;
          run_d   = 2'd1;
        end
      end
      ST_SINGLE: begin
        if (tick) begin
          if (cool) begin
            state_d = ST_REDUN;
            run_d   = 2'd0;
          end else if (hot) begin
            if (run_q == 2'd2 && !partial_only) begin
              state_d  = ST_SCALED;
              run_d    = 2'd3;
              load_lvl = 1'b1;
            end else if (run_q != 2'd3) begin
              run_d = run_q + 2'd1;
            end
          end
        end
      end
      ST_SCALED: begin
        if (tick) begin
          if (cool) begin
            state_d = ST_RESTORE;
            run_d   = 2'd0;
          end else if (hot) begin
            load_lvl = 1'b1;
          end
        end
      end
      ST_RESTORE: begin
        state_d = ST_REDUN;
      end
      default: begin
        state_d = ST_WARMUP;
        run_d   = 2'd0;
      end
    endcase
  end

  assign off_inc = tick && (state_q == ST_SINGLE || state_q == ST_SCALED);
  assign state   = state_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_WARMUP;
      run_q   <= 2'd0;
    end else begin
      state_q <= state_d;
      run_q   <= run_d;
    end
  end
endmodule

// File: rtl/tmgr_sat_counter.sv
module tmgr_sat_counter #(
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          inc,
  output logic [CW-1:0] count
);
  localparam logic [CW-1:0] TOP = {CW{1'b1}};

  logic [CW-1:0] cnt_q;
  logic          cnt_en;

  assign cnt_en = inc && (cnt_q != TOP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_q + 1'b1;
  end

  assign count = cnt_q;
endmodule

// File: rtl/thermal_redundancy_mgr.sv
module thermal_redundancy_mgr
  import tmgr_pkg::*;
#(
  parameter int TW   = 8,
  parameter int HYST = 0,
  parameter int CW   = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          epoch_tick,
  input  logic          warmup_done,
  input  logic          partial_only,
  input  logic [TW-1:0] temp_max,
  input  logic [TW-1:0] temp_thresh,
  output logic          redun_en,
  output logic          dvs_req,
  output logic [TW-1:0] dvs_temp,
  output logic [CW-1:0] off_epochs
);
  logic        hot, cool, load_lvl, off_inc;
  tmgr_state_e state;
  logic [TW-1:0] lvl_q;

  tmgr_compare #(.TW(TW), .HYST(HYST)) u_cmp (
    .temp_max    (temp_max),
    .temp_thresh (temp_thresh),
    .hot         (hot),
    .cool        (cool)
  );

  tmgr_fsm u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .tick         (epoch_tick),
    .warm_done    (warmup_done),
    .partial_only (partial_only),
    .hot          (hot),
    .cool         (cool),
    .state        (state),
    .load_lvl     (load_lvl),
    .off_inc      (off_inc)
  );

  tmgr_sat_counter #(.CW(CW)) u_off (
    .clk   (clk),
    .rst_n (rst_n),
    .inc   (off_inc),
    .count (off_epochs)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        lvl_q <= '0;
    else if (load_lvl) lvl_q <= temp_max;
  end

  assign dvs_temp = lvl_q;
  assign dvs_req  = (state == ST_SCALED);
  assign redun_en = (state == ST_WARMUP) || (state == ST_REDUN) || (state == ST_RESTORE);
endmodule

// File: rtl/tmgr_chk.sv
module tmgr_chk #(
  parameter int TW = 8,
  parameter int CW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          epoch_tick,
  input logic          partial_only,
  input logic [TW-1:0] temp_max,
  input logic [TW-1:0] temp_thresh,
  input logic          redun_en,
  input logic          dvs_req,
  input logic [CW-1:0] off_epochs
);
  // R3
  drop_on_hot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(redun_en) |-> ($past(epoch_tick) && $past(temp_max >= temp_thresh)));

  // R5
  scale_on_hot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dvs_req) |-> ($past(epoch_tick) && $past(temp_max >= temp_thresh) && !redun_en));

  // R7
  restore_together_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dvs_req) |-> redun_en);

  // R9
  no_scale_partial_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (partial_only && !dvs_req) |=> !dvs_req);

  // R10
  count_monotone_chk: assert property (@(posedge clk) disable iff (!rst_n)
    off_epochs >= $past(off_epochs));

  // R11
  quiet_between_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(epoch_tick) |-> ($stable(dvs_req) && $stable(off_epochs)));
endmodule

bind thermal_redundancy_mgr tmgr_chk #(.TW(TW), .CW(CW)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .epoch_tick   (epoch_tick),
  .partial_only (partial_only),
  .temp_max     (temp_max),
  .temp_thresh  (temp_thresh),
  .redun_en     (redun_en),
  .dvs_req      (dvs_req),
  .off_epochs   (off_epochs)
);

// File: tb/thermal_redundancy_mgr_tb.sv
module thermal_redundancy_mgr_tb;
  localparam int TW = 8;
  localparam int HYST = 2;
  localparam int CW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          epoch_tick = 1'b0;
  logic          warmup_done = 1'b0;
  logic          partial_only = 1'b0;
  logic [TW-1:0] temp_max = '0;
  logic [TW-1:0] temp_thresh = 8'd80;
  logic          redun_en, dvs_req;
  logic [TW-1:0] dvs_temp;
  logic [CW-1:0] off_epochs;

  typedef struct {
    logic          redun;
    logic          dvs;
    logic [TW-1:0] lvl;
    logic [CW-1:0] cnt;
    string         req;
  } exp_t;

  exp_t  sb_q[$];
  event  sample_ev;
  int    total = 0;
  int    bad = 0;
  bit    done = 1'b0;
  int    cycles = 0;

  always #2.5 clk = ~clk;

  thermal_redundancy_mgr #(.TW(TW), .HYST(HYST), .CW(CW)) u_dut (
    .clk (clk), .rst_n (rst_n), .epoch_tick (epoch_tick),
    .warmup_done (warmup_done), .partial_only (partial_only),
    .temp_max (temp_max), .temp_thresh (temp_thresh),
    .redun_en (redun_en), .dvs_req (dvs_req),
    .dvs_temp (dvs_temp), .off_epochs (off_epochs)
  );

  // monitor: pops one expected item per sample event
  always @(sample_ev) begin
    exp_t e;
    e = sb_q.pop_front();
    total++;
    if (redun_en !== e.redun || dvs_req !== e.dvs || dvs_temp !== e.lvl || off_epochs !== e.cnt) begin
      bad++;
      $display("FAIL %s: got redun=%0b dvs=%0b lvl=%0d cnt=%0d exp redun=%0b dvs=%0b lvl=%0d cnt=%0d",
               e.req, redun_en, dvs_req, dvs_temp, off_epochs, e.redun, e.dvs, e.lvl, e.cnt);
    end
  end

  task automatic push(input logic r, input logic d, input logic [TW-1:0] l,
                      input logic [CW-1:0] c, input string req);
    exp_t e;
    e.redun = r; e.dvs = d; e.lvl = l; e.cnt = c; e.req = req;
    sb_q.push_back(e);
  endtask

  // one epoch: drive sample, pulse tick, check after the update edge
  task automatic epoch(input logic [TW-1:0] t, input logic r, input logic d,
                       input logic [TW-1:0] l, input logic [CW-1:0] c, input string req);
    push(r, d, l, c, req);
    @(negedge clk);
    temp_max   = t;
    epoch_tick = 1'b1;
    @(negedge clk);
    epoch_tick = 1'b0;
    -> sample_ev;
    repeat (3) @(negedge clk);
  endtask

  task automatic idle_check(input logic r, input logic d, input logic [TW-1:0] l,
                            input logic [CW-1:0] c, input string req);
    push(r, d, l, c, req);
    @(negedge clk);
    -> sample_ev;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      done = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog: got cycles=%0d exp below 20000", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    idle_check(1, 0, 0, 0, "R1 reset state");
    rst_n = 1'b1;
    idle_check(1, 0, 0, 0, "R1 after release");

    epoch(8'd99, 1, 0, 0, 0, "R2 hot before warm-up 1");
    epoch(8'd99, 1, 0, 0, 0, "R2 hot before warm-up 2");
    warmup_done = 1'b1;
    epoch(8'd99, 1, 0, 0, 0, "R2 extra interval ignores hot");

    epoch(8'd80, 0, 0, 0, 0, "R3 equal to limit drops redundancy");
    epoch(8'd79, 0, 0, 0, 1, "R8 band sample holds single mode");
    epoch(8'd77, 1, 0, 0, 2, "R4 cool sample re-enables without scaling");

    epoch(8'd90, 0, 0, 0, 2, "R3 hot drops redundancy again");
    epoch(8'd91, 0, 0, 0, 3, "R5 second hot no scaling yet");
    epoch(8'd85, 0, 1, 8'd85, 4, "R5 third hot engages scaling");

    temp_max = 8'd50;
    repeat (4) @(negedge clk);
    idle_check(0, 1, 8'd85, 4, "R11 temperature between pulses ignored");

    epoch(8'd95, 0, 1, 8'd95, 5, "R6 hot while scaled reloads level");
    epoch(8'd60, 1, 0, 8'd95, 6, "R7 cool restores both together");

    epoch(8'd88, 0, 0, 8'd95, 6, "R3 hot after restore");
    epoch(8'd79, 0, 0, 8'd95, 7, "R8 band inside violation run");
    epoch(8'd88, 0, 0, 8'd95, 7, "R10 counter saturates");
    epoch(8'd88, 0, 1, 8'd88, 7, "R8 run resumes to scaling, R10 held");
    epoch(8'd50, 1, 0, 8'd88, 7, "R7 restore");

    partial_only = 1'b1;
    epoch(8'd90, 0, 0, 8'd88, 7, "R9 hot drops redundancy");
    epoch(8'd90, 0, 0, 8'd88, 7, "R9 second hot");
    epoch(8'd90, 0, 0, 8'd88, 7, "R9 third hot no scaling");
    epoch(8'd90, 0, 0, 8'd88, 7, "R9 fourth hot no scaling");
    epoch(8'd40, 1, 0, 8'd88, 7, "R9 cool re-enables");

    repeat (2) @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule